// File: doc/BRIEF.md
# Double-Buffered 16-bit PWM Generator

This block produces one pulse-width-modulated output from a 16-bit up-counter. The counter advances once per tick of a power-of-two prescaler. It runs from zero up to an active period value and then wraps to zero. The output rises at each wrap and falls when the counter matches an active duty value. Software reaches the block through a byte-wide write port that carries an address and a strobe. Period and duty are each written as a low byte and a high byte.

Each 16-bit value has two stages: a staged copy that the byte writes fill, and an active copy that the counter compares against. A staged value moves to the active copy only after both of its bytes have been written, and then only at the next wrap, so a PWM cycle that is under way is never disturbed. There is one exception. Setting the enable bit from the disabled state copies both staged values straight into the active registers, even when only one byte of a pair was written.

A two-state machine controls the block. In `ST_OFF` the counter is held at zero and the output is low. The *start* transition (`ST_OFF` to `ST_RUN`) is taken on a control write with the enable bit set, and it loads the active registers. The *stop* transition (`ST_RUN` to `ST_OFF`) is taken on a control write with the enable bit clear. A control write that leaves the enable bit unchanged only updates the prescaler.

Top module: `dbuf_pwm`

## Requirements
- R1: A write takes place at a rising clock edge while `wr_en` is high. `wr_addr` selects the target: 0 period low byte, 1 period high byte, 2 duty low byte, 3 duty high byte, 4 control. In the control byte, bit 0 is the enable and bits 3:1 are the prescale exponent.
- R2: After reset, and in every cycle while the block is disabled, `pwm_out` is low and the counter is zero.
- R3: Take prescale exponent 0, active period P and active duty D with 0 < D ≤ P. The clock edge that accepts an enabling control write starts a cycle at count 0 with the output high. The output then stays high for D clocks and low for P+1−D clocks, repeating every P+1 clocks.
- R4: An active duty of 0 keeps the output low for the whole run. An active duty greater than the active period keeps it high.
- R5: Writing only one byte of the period or duty pair leaves the active value unchanged, however many cycles pass.
- R6: Once both bytes of a pair have been written, the cycle in progress finishes with the old value and the new value governs from the next wrap onward.
- R7: Clearing the enable bit and then setting it again restarts the waveform from count 0 with the output high.
- R8: An enabling write from the disabled state makes the staged bytes of both pairs active at once, including a pair with only one byte written since the last load.
- R9: The counter advances once every 2^E clocks, where E is the prescale exponent. A new exponent takes effect immediately, even in the middle of a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 3 | Register select for the write |
| wr_data | input | 8 | Write data byte |
| pwm_out | output | 1 | PWM waveform |

## Verification
The assertions check several things on every cycle. The disabled state forces a low output and a zero count. The counter never passes the active period and moves only by one step or by a wrap to zero. The active period changes only in a cycle that committed a staged value. Other behaviours can only be shown by the bench's scenarios. These are the exact pulse shape after an enable, the way half-written pairs are ignored and then committed, the cycle-boundary timing of a commit, the immediate load on re-enable, and the immediate effect of a prescale change. The bench observes each of them as the spacing of output edges.

// File: rtl/dbuf_pwm_pkg.sv
package dbuf_pwm_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_PER_LO  = 3'd0,
        A_PER_HI  = 3'd1,
        A_DUTY_LO = 3'd2,
        A_DUTY_HI = 3'd3,
        A_CTRL    = 3'd4
    } pwm_addr_e;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } pwm_state_e;

    // index of each staged pair in the pair arrays
    localparam int PAIR_PER  = 0;
    localparam int PAIR_DUTY = 1;
    localparam int N_PAIRS   = 2;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PS_W-1:0] ps_sel,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W:0]   one_sh;
    logic [DIV_W:0]   mask_w;
    logic [DIV_W-1:0] mask;

    // free-running divider; never cleared by a prescale write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    always_comb begin
        one_sh = {{DIV_W{1'b0}}, 1'b1} << ps_sel;
        mask_w = one_sh - {{DIV_W{1'b0}}, 1'b1};
        mask   = mask_w[DIV_W-1:0];
        tick   = ((div_q & mask) == mask);
    end

endmodule

// File: rtl/pwm_pair_stage.sv
module pwm_pair_stage #(
    parameter int BYTE_W = 8,
    localparam int VAL_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] din,
    input  logic              commit,
    output logic [VAL_W-1:0]  staged,
    output logic              pending
);
    logic [BYTE_W-1:0] lo_q, hi_q;
    logic              lo_seen_q, hi_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q      <= '0;
            hi_q      <= '0;
            lo_seen_q <= 1'b0;
            hi_seen_q <= 1'b0;
        end else begin
            if (wr_lo) lo_q <= din;
            if (wr_hi) hi_q <= din;
            // a byte written in the commit cycle counts toward the next value
            if (wr_lo)       lo_seen_q <= 1'b1;
            else if (commit) lo_seen_q <= 1'b0;
            if (wr_hi)       hi_seen_q <= 1'b1;
            else if (commit) hi_seen_q <= 1'b0;
        end
    end

    assign staged  = {hi_q, lo_q};
    assign pending = lo_seen_q & hi_seen_q;

endmodule

// File: rtl/pwm_core.sv
module pwm_core
    import dbuf_pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_en,
    input  logic             tick,
    input  logic [CNT_W-1:0] per_stg,
    input  logic             per_pend,
    input  logic [CNT_W-1:0] duty_stg,
    input  logic             duty_pend,
    output logic             per_commit,
    output logic             duty_commit,
    output logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] per_act,
    output logic             pwm_out
);
    pwm_state_e       state_q, state_nxt;
    logic [CNT_W-1:0] cnt_q, cnt_nxt, cnt_step;
    logic [CNT_W-1:0] per_q, duty_q, per_eff, duty_eff;
    logic             out_q, out_nxt;
    logic             load, wrap;

    // next-state decode
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_OFF: if (ctl_wr && ctl_en)  state_nxt = ST_RUN;
            ST_RUN: if (ctl_wr && !ctl_en) state_nxt = ST_OFF;
            default: state_nxt = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_nxt;
    end

    always_comb begin
        load        = (state_q == ST_OFF) && (state_nxt == ST_RUN);
        wrap        = (state_q == ST_RUN) && (state_nxt == ST_RUN)
                      && tick && (cnt_q == per_q);
        per_commit  = load || (wrap && per_pend);
        duty_commit = load || (wrap && duty_pend);
        per_eff     = per_commit  ? per_stg  : per_q;
        duty_eff    = duty_commit ? duty_stg : duty_q;
        cnt_step    = wrap ? '0 : cnt_q + 1'b1;

        cnt_nxt = cnt_q;
        out_nxt = out_q;
        if (state_nxt == ST_OFF) begin
            cnt_nxt = '0;
            out_nxt = 1'b0;
        end else if (load) begin
            cnt_nxt = '0;
            out_nxt = (duty_eff != '0);
        end else if (tick) begin
            cnt_nxt = cnt_step;
            // a duty match wins over the wrap set
            if (cnt_step == duty_eff) out_nxt = 1'b0;
            else if (wrap)            out_nxt = 1'b1;
        end
    end

    // output-side registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            out_q  <= 1'b0;
            per_q  <= '0;
            duty_q <= '0;
        end else begin
            cnt_q  <= cnt_nxt;
            out_q  <= out_nxt;
            per_q  <= per_eff;
            duty_q <= duty_eff;
        end
    end

    assign run     = (state_q == ST_RUN);
    assign cnt     = cnt_q;
    assign per_act = per_q;
    assign pwm_out = out_q;

endmodule

// File: rtl/dbuf_pwm.sv
module dbuf_pwm
    import dbuf_pwm_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int PS_W   = 3,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              pwm_out
);
    logic [N_PAIRS-1:0]            pair_lo_wr, pair_hi_wr, pair_pend, pair_commit;
    logic [N_PAIRS-1:0][CNT_W-1:0] pair_val;
    logic [PS_W-1:0]               ps_q;
    logic                          ctl_wr, tick;
    logic                          run_w;
    logic [CNT_W-1:0]              cnt_w, per_act_w;
    logic                          ctl_unused;

    assign ctl_wr     = wr_en && (wr_addr == A_CTRL);
    assign ctl_unused = ^wr_data[BYTE_W-1:PS_W+1];

    assign pair_lo_wr[PAIR_PER]  = wr_en && (wr_addr == A_PER_LO);
    assign pair_hi_wr[PAIR_PER]  = wr_en && (wr_addr == A_PER_HI);
    assign pair_lo_wr[PAIR_DUTY] = wr_en && (wr_addr == A_DUTY_LO);
    assign pair_hi_wr[PAIR_DUTY] = wr_en && (wr_addr == A_DUTY_HI);

    // prescale exponent is applied from the next clock, no boundary wait
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ps_q <= '0;
        else if (ctl_wr) ps_q <= wr_data[PS_W:1];
    end

    for (genvar g = 0; g < N_PAIRS; g++) begin : g_pair
        pwm_pair_stage #(.BYTE_W(BYTE_W)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_lo   (pair_lo_wr[g]),
            .wr_hi   (pair_hi_wr[g]),
            .din     (wr_data),
            .commit  (pair_commit[g]),
            .staged  (pair_val[g]),
            .pending (pair_pend[g])
        );
    end

    pwm_prescaler #(.PS_W(PS_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .ps_sel (ps_q),
        .tick   (tick)
    );

    pwm_core #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_wr      (ctl_wr),
        .ctl_en      (wr_data[0]),
        .tick        (tick),
        .per_stg     (pair_val[PAIR_PER]),
        .per_pend    (pair_pend[PAIR_PER]),
        .duty_stg    (pair_val[PAIR_DUTY]),
        .duty_pend   (pair_pend[PAIR_DUTY]),
        .per_commit  (pair_commit[PAIR_PER]),
        .duty_commit (pair_commit[PAIR_DUTY]),
        .run         (run_w),
        .cnt         (cnt_w),
        .per_act     (per_act_w),
        .pwm_out     (pwm_out)
    );

endmodule

// File: rtl/dbuf_pwm_chk.sv
module dbuf_pwm_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwm_out,
    input logic             run,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] per_act,
    input logic             per_commit
);
    // R2
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !pwm_out);

    // R2
    off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (cnt == '0));

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= per_act));

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$stable(cnt)) |->
            ((cnt == $past(cnt) + 1'b1) || (cnt == '0)));

    // R6
    per_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(per_act) |-> $past(per_commit));

endmodule

bind dbuf_pwm dbuf_pwm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_out    (pwm_out),
    .run        (run_w),
    .cnt        (cnt_w),
    .per_act    (per_act_w),
    .per_commit (pair_commit[0])
);

// File: tb/dbuf_pwm_tb.sv
`timescale 1ns/1ps
module dbuf_pwm_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       pwm_out;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dbuf_pwm u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_out (pwm_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R1: write takes place at the posedge between the two negedges
    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_rise(output int t);
        logic prev;
        prev = pwm_out;
        t = -1;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!prev && pwm_out) begin t = cyc; break; end
            prev = pwm_out;
        end
    endtask

    // enable write, then compare N samples with (k mod (P+1)) < D
    task automatic run_shape(input logic [7:0] ctl, input int p, input int d,
                             input int n, input string req);
        int bad;
        int first_bad;
        bad = 0; first_bad = -1;
        reg_wr(3'd4, ctl);
        for (int k = 0; k < n; k++) begin
            if (k > 0) @(negedge clk);
            if (pwm_out !== ((k % (p + 1)) < d)) begin
                bad++;
                if (first_bad < 0) first_bad = k;
            end
        end
        chk(bad == 0, req, first_bad, -1);
    endtask

    task automatic t_reset;
        chk(pwm_out === 1'b0, "R2 reset low", int'(pwm_out), 0);
    endtask

    task automatic t_enable_blank;
        int highs;
        highs = 0;
        reg_wr(3'd4, 8'h01);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (pwm_out) highs++;
        end
        chk(highs == 0, "R4 zero regs keep low", highs, 0);
        reg_wr(3'd4, 8'h00);
    endtask

    task automatic t_basic;
        reg_wr(3'd0, 8'd9); reg_wr(3'd1, 8'd0);
        reg_wr(3'd2, 8'd3); reg_wr(3'd3, 8'd0);
        run_shape(8'h01, 9, 3, 40, "R3 shape P9 D3");
    endtask

    task automatic t_half_and_full;
        int t0, t1, t2;
        reg_wr(3'd0, 8'h13);            // low byte only
        wait_rise(t0); wait_rise(t1); wait_rise(t2);
        chk(t1 - t0 == 10, "R5 half write ignored", t1 - t0, 10);
        chk(t2 - t1 == 10, "R5 half write ignored", t2 - t1, 10);
        wait_rise(t0);
        repeat (4) @(negedge clk);
        reg_wr(3'd1, 8'h00);            // pair complete
        wait_rise(t1); wait_rise(t2);
        chk(t1 - t0 == 10, "R6 current cycle kept", t1 - t0, 10);
        chk(t2 - t1 == 20, "R6 new period at wrap", t2 - t1, 20);
    endtask

    task automatic t_disable_restart;
        int highs;
        highs = 0;
        reg_wr(3'd4, 8'h00);
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (pwm_out) highs++;
        end
        chk(highs == 0, "R2 disabled low", highs, 0);
        run_shape(8'h01, 19, 3, 60, "R7 restart from zero");
    endtask

    task automatic t_partial_load;
        reg_wr(3'd4, 8'h00);
        reg_wr(3'd2, 8'd8);             // duty low only
        run_shape(8'h01, 19, 8, 60, "R8 partial load on enable");
    endtask

    task automatic t_duty_edges;
        reg_wr(3'd4, 8'h00);
        reg_wr(3'd2, 8'd0);
        run_shape(8'h01, 19, 0, 60, "R4 duty zero low");
        reg_wr(3'd4, 8'h00);
        reg_wr(3'd2, 8'd32);
        run_shape(8'h01, 19, 20, 60, "R4 duty above period high");
    endtask

    task automatic t_prescale;
        int t0, t1, t2;
        reg_wr(3'd4, 8'h00);
        reg_wr(3'd0, 8'd9);
        reg_wr(3'd2, 8'd3);
        reg_wr(3'd4, 8'h03);            // enable, exponent 1
        wait_rise(t0); wait_rise(t1); wait_rise(t2);
        chk(t1 - t0 == 20, "R9 divide by 2", t1 - t0, 20);
        chk(t2 - t1 == 20, "R9 divide by 2", t2 - t1, 20);
        reg_wr(3'd4, 8'h00);
        reg_wr(3'd0, 8'd199);
        reg_wr(3'd4, 8'h01);            // enable, exponent 0
        wait_rise(t0);
        reg_wr(3'd4, 8'h07);            // exponent 3 mid-cycle
        wait_rise(t1);
        chk((t1 - t0 > 200) && (t1 - t0 < 1600), "R9 immediate prescale",
            t1 - t0, 1590);
        wait_rise(t2);
        chk(t2 - t1 == 1600, "R9 divide by 8", t2 - t1, 1600);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_enable_blank;
        t_basic;
        t_half_and_full;
        t_disable_restart;
        t_partial_load;
        t_duty_edges;
        t_prescale;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule